// File: doc/BRIEF.md
# Streaming Parallel Interference Cancellation Detector

This block turns a stream of matched-filter soft outputs for K users into hard bit decisions, one vector per bit period. Bits are not collected into a detection window. Each accepted input vector moves the whole pipeline forward by one bit. The pipeline has three decision stages. The first stage takes the sign of the soft value for each user. Each of the two cancellation stages then recomputes the decision for an older bit. It removes the interference predicted from the previous stage's decisions for the bit before, the bit itself and the bit after, and then takes the sign again.

The correlation between users is given by two K x K matrices held on input ports. The first matrix couples a bit to the previous bit of every user. The second couples users within the same bit. The coupling to the next bit is the transpose of the first matrix, so no third matrix is needed. Adjacent stages work two bits apart. The soft vector for a bit is delayed alongside the decisions, so every stage reuses the value the first stage saw for that bit. Computing the matrices and the matched filter is done elsewhere. The matrices must stay stable while a stream is flowing.

Top module: `mud_stream_detector`

## Requirements
- R1: When `rst` is high at a rising edge, all stored decisions, soft values and fill flags are cleared. From the next cycle `valid_out` is 0 and `dec_out` is 0.
- R2: A bit is accepted at a rising edge where `valid_in` is high. Bits are numbered from 0 after reset. The final decision for bit i appears with `valid_out` high for exactly one cycle, in the cycle after the edge that accepts bit i+4. The first four accepted bits produce no output. At all other times `valid_out` is low and `dec_out` holds its value.
- R3: The first-stage decision for each user is the sign of that user's soft input.
- R4: Stages 2 and 3 compute, for user a and bit i, `y[a] - sum_b P[a][b]*d_{i-1}[b] - sum_b Q[a][b]*d_i[b] - sum_b P[b][a]*d_{i+1}[b]`. Here P is `l_mat`, Q is `c_mat`, and d is the previous stage's ±1 decisions. The entry in row a, column b sits at bits `[(a*K+b)*E_W +: E_W]` as a signed value. User u's soft input sits at `y_in[u*Y_W +: Y_W]`. `dec_out` carries the stage-3 result.
- R5: A decision bit of 1 means -1 (the value is negative). A bit of 0 means +1 (the value is zero or positive). This holds for `dec_out` and for every internal stage.
- R6: Any term that refers to a bit before bit 0 of the current stream contributes zero.
- R7: The diagonal entries `Q[a][a]` have no effect on any decision.
- R8: Cycles with `valid_in` low change no stored state and produce no output. A bit's result does not depend on idle gaps in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Accept `y_in` as the next bit this cycle |
| y_in | input | K*Y_W (48) | Signed soft value per user, user u at `[u*Y_W +: Y_W]` |
| l_mat | input | K*K*E_W (128) | Signed previous-bit coupling matrix, row-major |
| c_mat | input | K*K*E_W (128) | Signed same-bit coupling matrix, row-major, diagonal unused |
| valid_out | output | 1 | One-cycle pulse marking a new final decision vector |
| dec_out | output | K (4) | Final decisions, 1 = -1, 0 = +1 |

## Verification
The output for bit i is due in exactly one place: the cycle after the edge that accepts bit i+4, whatever idle cycles come between inputs. The bench counts accepted bits itself. Each output is paired with the bit index it belongs to, and the count of accepted bits is compared with that index plus five when `valid_out` is seen. Any output while nothing is due counts as a failure. Expected vectors are queued only at the acceptance that makes them due, so the queue must be empty after each output and at the end of each phase.

// File: rtl/mud_pkg.sv
`timescale 1ns/1ps
package mud_pkg;
  // Bits of separation between consecutive decision stages.
  localparam int STAGE_GAP = 2;
  // Decision history taps a cancellation stage reads: next, current, previous.
  localparam int DEC_TAPS = 3;

  // Linear index of a row-major square matrix entry.
  function automatic int flat_ent(input int row, input int col, input int n);
    return row * n + col;
  endfunction
endpackage

// File: rtl/mud_delay.sv
`timescale 1ns/1ps
module mud_delay #(
  parameter int W = 8,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tail
);
  logic [D-1:0][W-1:0] line;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (en) begin
      line[0] <= din;
      for (int i = 1; i < D; i++) line[i] <= line[i-1];
    end
  end

  assign tail = line[D-1];
endmodule

// File: rtl/mud_hist.sv
`timescale 1ns/1ps
module mud_hist #(
  parameter int W = 4,
  parameter int D = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [W-1:0]        din,
  input  logic                din_known,
  output logic [D-1:0][W-1:0] taps,
  output logic [D-1:0]        known
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps  <= '0;
      known <= '0;
    end else if (en) begin
      taps[0]  <= din;
      known[0] <= din_known;
      for (int i = 1; i < D; i++) begin
        taps[i]  <= taps[i-1];
        known[i] <= known[i-1];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < D - 1; g++) begin : g_ord
      // R6
      known_order_chk: assert property (@(posedge clk) disable iff (rst)
        known[g+1] |-> known[g]);
    end
  endgenerate
endmodule

// File: rtl/mud_pic_stage.sv
`timescale 1ns/1ps
module mud_pic_stage #(
  parameter int K   = 4,
  parameter int Y_W = 12,
  parameter int E_W = 8
) (
  input  logic [K*Y_W-1:0]   y_vec,
  input  logic [K-1:0]       d_prev,
  input  logic [K-1:0]       d_cur,
  input  logic [K-1:0]       d_next,
  input  logic               k_prev,
  input  logic               k_cur,
  input  logic               k_next,
  input  logic [K*K*E_W-1:0] l_flat,
  input  logic [K*K*E_W-1:0] c_flat,
  output logic [K-1:0]       dec
);
  localparam int BASE_W = (Y_W > E_W + 1) ? Y_W : E_W + 1;
  localparam int ACC_W  = BASE_W + $clog2(3 * K) + 1;

  function automatic logic signed [ACC_W-1:0] ext_y(input logic [Y_W-1:0] v);
    return {{(ACC_W-Y_W){v[Y_W-1]}}, v};
  endfunction

  // Contribution of one matrix entry times a ±1 decision; zero if unused.
  function automatic logic signed [ACC_W-1:0] term(input logic [E_W-1:0] e,
                                                   input logic neg,
                                                   input logic use_it);
    logic signed [ACC_W-1:0] x;
    x = {{(ACC_W-E_W){e[E_W-1]}}, e};
    if (!use_it) return '0;
    return neg ? -x : x;
  endfunction

  logic signed [ACC_W-1:0] resid [K];

  always_comb begin
    for (int a = 0; a < K; a++) begin
      resid[a] = ext_y(y_vec[a*Y_W +: Y_W]);
      for (int b = 0; b < K; b++) begin
        resid[a] = resid[a]
          - term(l_flat[mud_pkg::flat_ent(a, b, K)*E_W +: E_W], d_prev[b], k_prev)
          - term(c_flat[mud_pkg::flat_ent(a, b, K)*E_W +: E_W], d_cur[b],
                 k_cur && (a != b))
          - term(l_flat[mud_pkg::flat_ent(b, a, K)*E_W +: E_W], d_next[b], k_next);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < K; g++) begin : g_sign
      assign dec[g] = resid[g][ACC_W-1];
    end
  endgenerate
endmodule

// File: rtl/mud_stream_detector.sv
`timescale 1ns/1ps
module mud_stream_detector #(
  parameter int K   = 4,
  parameter int Y_W = 12,
  parameter int E_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_in,
  input  logic [K*Y_W-1:0]   y_in,
  input  logic [K*K*E_W-1:0] l_mat,
  input  logic [K*K*E_W-1:0] c_mat,
  output logic               valid_out,
  output logic [K-1:0]       dec_out
);
  localparam int GAP  = mud_pkg::STAGE_GAP;
  localparam int TAPS = mud_pkg::DEC_TAPS;
  localparam int YV_W = K * Y_W;

  logic                   advance;
  logic [K-1:0]           d1_new, d2_new, d3_new;
  logic [YV_W-1:0]        y_s2, y_s3;
  logic [TAPS-1:0][K-1:0] h1_d, h2_d;
  logic [TAPS-1:0]        h1_k, h2_k;
  logic                   out_fire;

  assign advance = valid_in;

  genvar g;
  generate
    for (g = 0; g < K; g++) begin : g_front
      assign d1_new[g] = y_in[g*Y_W + Y_W - 1];
    end
  endgenerate

  // Soft values travel alongside the stages.
  mud_delay #(.W(YV_W), .D(GAP)) u_ydly2 (
    .clk(clk), .rst(rst), .en(advance), .din(y_in), .tail(y_s2));
  mud_delay #(.W(YV_W), .D(GAP)) u_ydly3 (
    .clk(clk), .rst(rst), .en(advance), .din(y_s2), .tail(y_s3));

  mud_hist #(.W(K), .D(TAPS)) u_hist1 (
    .clk(clk), .rst(rst), .en(advance), .din(d1_new), .din_known(1'b1),
    .taps(h1_d), .known(h1_k));

  mud_pic_stage #(.K(K), .Y_W(Y_W), .E_W(E_W)) u_stage2 (
    .y_vec(y_s2), .d_prev(h1_d[2]), .d_cur(h1_d[1]), .d_next(h1_d[0]),
    .k_prev(h1_k[2]), .k_cur(h1_k[1]), .k_next(h1_k[0]),
    .l_flat(l_mat), .c_flat(c_mat), .dec(d2_new));

  mud_hist #(.W(K), .D(TAPS)) u_hist2 (
    .clk(clk), .rst(rst), .en(advance), .din(d2_new), .din_known(h1_k[1]),
    .taps(h2_d), .known(h2_k));

  mud_pic_stage #(.K(K), .Y_W(Y_W), .E_W(E_W)) u_stage3 (
    .y_vec(y_s3), .d_prev(h2_d[2]), .d_cur(h2_d[1]), .d_next(h2_d[0]),
    .k_prev(h2_k[2]), .k_cur(h2_k[1]), .k_next(h2_k[0]),
    .l_flat(l_mat), .c_flat(c_mat), .dec(d3_new));

  assign out_fire = advance && h2_k[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      dec_out   <= '0;
    end else begin
      valid_out <= out_fire;
      if (out_fire) dec_out <= d3_new;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !valid_out);
  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $past(valid_in));
  // R2
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_out |-> $stable(dec_out));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
endmodule

// File: tb/mud_stream_detector_test.sv
`timescale 1ns/1ps
module mud_stream_detector_test;
  localparam int K = 4;
  localparam int YW = 12;
  localparam int EW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_in = 1'b0;
  logic [K*YW-1:0] y_in = '0;
  logic [K*K*EW-1:0] l_mat = '0;
  logic [K*K*EW-1:0] c_mat = '0;
  logic valid_out;
  logic [K-1:0] dec_out;

  mud_stream_detector #(.K(K), .Y_W(YW), .E_W(EW)) uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .y_in(y_in),
    .l_mat(l_mat), .c_mat(c_mat), .valid_out(valid_out), .dec_out(dec_out));

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int Lm [K][K];
  int Cm [K][K];
  int ys [256][K];
  int d1 [256][K];
  int d2 [256][K];
  int d3 [256][K];
  int nb = 0;
  int sent = 0;
  int n_out = 0;
  int exp_bit [$];
  logic [K-1:0] exp_dec [$];
  string req_tag = "R1";

  task automatic chk(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int sg(input int v);
    return (v < 0) ? -1 : 1;
  endfunction

  function automatic int pv(input int st, input int j, input int u);
    if (j < 0) return 0;                          // R6: before bit 0
    return (st == 1) ? d1[j][u] : d2[j][u];
  endfunction

  // Residual for user u of bit b, given the decisions of stage st.
  function automatic int resid(input int st, input int b, input int u);
    int r = ys[b][u];
    for (int v = 0; v < K; v++) begin
      r -= Lm[u][v] * pv(st, b - 1, v);
      r -= Lm[v][u] * pv(st, b + 1, v);           // transpose for next bit
      if (v != u) r -= Cm[u][v] * pv(st, b, v);   // R7: own term skipped
    end
    return r;
  endfunction

  task automatic load_mats();
    for (int a = 0; a < K; a++)
      for (int b = 0; b < K; b++) begin
        l_mat[(a*K+b)*EW +: EW] = Lm[a][b][EW-1:0];
        c_mat[(a*K+b)*EW +: EW] = Cm[a][b][EW-1:0];
      end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    valid_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    nb = 0;
    sent = 0;
    n_out = 0;
    exp_bit.delete();
    exp_dec.delete();
  endtask

  // Driver: drives ys[nb] after gap idle cycles and queues what becomes due.
  task automatic push_bit(input int gap);
    logic [K-1:0] e;
    int b;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    valid_in = 1'b1;
    for (int u = 0; u < K; u++) y_in[u*YW +: YW] = ys[nb][u][YW-1:0];
    @(posedge clk);
    #1;
    valid_in = 1'b0;
    sent++;
    b = nb;
    for (int u = 0; u < K; u++) d1[b][u] = sg(ys[b][u]);
    if (b >= 1) for (int u = 0; u < K; u++) d2[b-1][u] = sg(resid(1, b - 1, u));
    if (b >= 2) for (int u = 0; u < K; u++) d3[b-2][u] = sg(resid(2, b - 2, u));
    if (b >= 4) begin
      for (int u = 0; u < K; u++) e[u] = (d3[b-4][u] < 0);  // R5 encoding
      exp_bit.push_back(b - 4);
      exp_dec.push_back(e);
    end
    nb++;
  endtask

  // Monitor: pops the scoreboard whenever an output is presented.
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      n_out++;
      if (exp_bit.size() == 0) begin
        chk("R2", 1, 0, "output with nothing due");
      end else begin
        int eb;
        logic [K-1:0] ed;
        eb = exp_bit.pop_front();
        ed = exp_dec.pop_front();
        chk("R2", sent, eb + 5, "latency in accepted bits");
        chk(req_tag, int'(dec_out), int'(ed), $sformatf("decisions of bit %0d", eb));
      end
    end
  end

  task automatic rand_mats(input int span, input bit diag);
    for (int a = 0; a < K; a++)
      for (int b = 0; b < K; b++) begin
        Lm[a][b] = $signed($urandom_range(2 * span, 0)) - span;
        Cm[a][b] = $signed($urandom_range(2 * span, 0)) - span;
        if (a == b && !diag) Cm[a][b] = 0;
        if (a == b && diag) Cm[a][b] = ($urandom_range(1, 0) != 0) ? 127 : -128;
      end
    load_mats();
  endtask

  task automatic rand_bits(input int n, input int span, input int maxgap);
    for (int i = 0; i < n; i++) begin
      for (int u = 0; u < K; u++) ys[nb][u] = $signed($urandom_range(2 * span, 0)) - span;
      push_bit($urandom_range(maxgap, 0));
    end
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk(tag, exp_bit.size(), 0, "outputs still due");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < K; a++)
      for (int b = 0; b < K; b++) begin Lm[a][b] = 0; Cm[a][b] = 0; end
    load_mats();
    do_reset();
    // R1: reset state
    chk("R1", int'(valid_out), 0, "valid_out after reset");
    chk("R1", int'(dec_out), 0, "dec_out after reset");

    // R3 and R5: no coupling, output is the delayed sign of y
    req_tag = "R3";
    begin
      int pat [12][K] = '{'{0, -1, 2047, -2048}, '{1, 0, -1, 5}, '{-7, 7, 0, 0},
                          '{100, -100, 3, -3}, '{-1, -1, -1, -1}, '{0, 0, 0, 0},
                          '{2047, 2047, -2048, -2048}, '{-5, 9, -9, 5},
                          '{0, -2048, 0, 2047}, '{12, -13, 14, -15},
                          '{-1, 1, -1, 1}, '{300, 0, -300, 0}};
      for (int i = 0; i < 4; i++) begin
        for (int u = 0; u < K; u++) ys[nb][u] = pat[i][u];
        push_bit(0);
      end
      // R2: first four bits yield nothing
      chk("R2", n_out, 0, "outputs during fill");
      for (int i = 4; i < 12; i++) begin
        for (int u = 0; u < K; u++) ys[nb][u] = pat[i][u];
        push_bit(0);
      end
    end
    drain("R5");

    // R4: directed flip, user 0 pulled negative by user 1's previous bit
    do_reset();
    req_tag = "R4";
    Lm[0][1] = 127;
    load_mats();
    for (int i = 0; i < 10; i++) begin
      ys[nb][0] = 60; ys[nb][1] = 200; ys[nb][2] = -40; ys[nb][3] = 10;
      push_bit(0);
    end
    drain("R4");

    // R4: random coupling, soft values comparable to interference
    do_reset();
    rand_mats(127, 1'b0);
    rand_bits(40, 400, 0);
    drain("R4");

    // R7: large diagonal in the same-bit matrix must be ignored
    do_reset();
    req_tag = "R7";
    rand_mats(60, 1'b1);
    rand_bits(30, 250, 0);
    drain("R7");

    // R8: idle gaps between accepted bits
    do_reset();
    req_tag = "R8";
    rand_mats(100, 1'b0);
    rand_bits(30, 350, 3);
    drain("R8");

    // R6: restart mid-stream, fill terms must start from zero again
    req_tag = "R6";
    rand_bits(7, 350, 0);
    do_reset();
    chk("R1", int'(valid_out), 0, "valid_out after mid-stream reset");
    for (int a = 0; a < K; a++)
      for (int b = 0; b < K; b++) Lm[a][b] = (a == b) ? 0 : 120;
    load_mats();
    rand_bits(12, 200, 1);
    drain("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule